// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Hazard Stall Unit

This block resolves the two source operands of the instruction in the decode stage of a five-stage 32-bit pipeline. For each operand it compares the source register index with the destination tags of three in-flight results. These are the execute-stage result, the memory-stage result and the result about to be written back. On a tag match it takes the operand from that result, and otherwise it passes through the register-file read value. Register zero always resolves to zero.

An in-flight result whose value does not exist yet has its valid flag clear. A load still in execute is the usual case. When the most recent matching result is in that state, the unit cannot supply the operand and lowers its ready output. Squashed or bubble slots present destination tag 0, so they never match.

All of the logic is combinational within the cycle. The ready output is the back-pressure signal of the decode stage. While `dec_ready` is low, the stage holds its instruction and the pipeline in front of it. The stage keeps the source indices and use flags stable until ready returns. The operand outputs are only meant to be consumed in a cycle where `dec_ready` is high. Ready is never held low by an operand the instruction does not read.

Top module: `operand_fwd`

## Requirements
- R1: When several in-flight results match a source index, the operand comes from the most recent one. The execute-stage result wins over the memory-stage result, and the memory-stage result wins over the writeback result.
- R2: When no in-flight result matches a nonzero source index, the operand equals the register-file read value for that source.
- R3: A source index of 0 yields an operand of 0. This holds whatever the register-file value and whatever records carry tag 0, and such a source never lowers `dec_ready`.
- R4: If the selected (highest-priority) matching result of a used operand has its valid flag clear, `dec_ready` is 0.
- R5: Only the highest-priority match decides. An invalid execute match lowers ready even when older results with the same tag are valid. A valid execute match keeps ready high even when older matches are invalid.
- R6: An operand whose use flag is 0 never lowers `dec_ready`, even when it matches an invalid result.
- R7: `dec_ready` is 0 exactly when at least one of the two operands has a stall condition. A stall on either operand alone is enough.
- R8: An invalid result whose tag matches neither source index has no effect on `dec_ready` or on the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src1_idx | input | 5 | First source register index |
| src1_used | input | 1 | Instruction reads the first source |
| rf_rd1 | input | 32 | Register-file value for the first source |
| src2_idx | input | 5 | Second source register index |
| src2_used | input | 1 | Instruction reads the second source |
| rf_rd2 | input | 32 | Register-file value for the second source |
| ex_tag | input | 5 | Destination index of the execute-stage result (0 = none) |
| ex_val | input | 32 | Execute-stage result value |
| ex_ok | input | 1 | Execute-stage result value is available |
| ma_tag | input | 5 | Destination index of the memory-stage result |
| ma_val | input | 32 | Memory-stage result value |
| ma_ok | input | 1 | Memory-stage result value is available |
| wb_tag | input | 5 | Destination index of the writeback result |
| wb_val | input | 32 | Writeback result value |
| wb_ok | input | 1 | Writeback result value is available |
| opnd1 | output | 32 | Resolved first operand |
| opnd2 | output | 32 | Resolved second operand |
| dec_ready | output | 1 | Decode stage may advance; low requests a stall |

## Verification
The block holds no state, so a wrong selection is visible on `opnd1`, `opnd2` or `dec_ready` in the same cycle its inputs are applied. No latency hides a fault. A broken priority chain shows up as an older stage's value on an operand when several tags collide. A missing use-flag gate or a wrong valid-flag test shows up as a spurious or missing stall. The stimulus therefore sets up tag collisions with mixed valid flags on both operands, so every selection path drives a distinct value to the ports.

// File: rtl/operand_fwd_pkg.sv
package operand_fwd_pkg;
  localparam int unsigned FWD_XLEN = 32;
  localparam int unsigned FWD_IDXW = 5;
  localparam int unsigned FWD_NREC = 3;
  localparam int unsigned FWD_NSRC = 2;
  // record slot order is priority order: slot 0 is the youngest result
  typedef enum int unsigned { SLOT_EX = 0, SLOT_MA = 1, SLOT_WB = 2 } rec_slot_e;
endpackage

// File: rtl/fwd_prio_pick.sv
module fwd_prio_pick #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      grant[i] = req[i] & ~seen;
      seen     = seen | req[i];
    end
  end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 5,
  parameter int unsigned NREC = 3
) (
  input  logic [IDXW-1:0]           idx,
  input  logic                      used,
  input  logic [XLEN-1:0]           rf_val,
  input  logic [NREC-1:0][IDXW-1:0] rec_tag,
  input  logic [NREC-1:0][XLEN-1:0] rec_val,
  input  logic [NREC-1:0]           rec_ok,
  output logic [XLEN-1:0]           opnd,
  output logic                      hazard
);
  logic [NREC-1:0] hit;
  logic [NREC-1:0] grant;
  logic            idx_zero;

  assign idx_zero = (idx == '0);

  for (genvar g = 0; g < NREC; g++) begin : g_cmp
    assign hit[g] = !idx_zero && (rec_tag[g] == idx);
  end

  fwd_prio_pick #(.N(NREC)) u_pick (
    .req   (hit),
    .grant (grant)
  );

  always_comb begin
    opnd = idx_zero ? '0 : rf_val;
    for (int i = 0; i < NREC; i++) begin
      if (grant[i]) opnd = rec_val[i];
    end
  end

  assign hazard = used && (|(grant & ~rec_ok));
endmodule

// File: rtl/operand_fwd.sv
module operand_fwd
  import operand_fwd_pkg::*;
#(
  parameter int unsigned XLEN = FWD_XLEN,
  parameter int unsigned IDXW = FWD_IDXW
) (
  input  logic [IDXW-1:0] src1_idx,
  input  logic            src1_used,
  input  logic [XLEN-1:0] rf_rd1,
  input  logic [IDXW-1:0] src2_idx,
  input  logic            src2_used,
  input  logic [XLEN-1:0] rf_rd2,
  input  logic [IDXW-1:0] ex_tag,
  input  logic [XLEN-1:0] ex_val,
  input  logic            ex_ok,
  input  logic [IDXW-1:0] ma_tag,
  input  logic [XLEN-1:0] ma_val,
  input  logic            ma_ok,
  input  logic [IDXW-1:0] wb_tag,
  input  logic [XLEN-1:0] wb_val,
  input  logic            wb_ok,
  output logic [XLEN-1:0] opnd1,
  output logic [XLEN-1:0] opnd2,
  output logic            dec_ready
);
  localparam int unsigned NREC = FWD_NREC;
  localparam int unsigned NSRC = FWD_NSRC;

  logic [NREC-1:0][IDXW-1:0] tags;
  logic [NREC-1:0][XLEN-1:0] vals;
  logic [NREC-1:0]           oks;

  assign tags[SLOT_EX] = ex_tag;
  assign tags[SLOT_MA] = ma_tag;
  assign tags[SLOT_WB] = wb_tag;
  assign vals[SLOT_EX] = ex_val;
  assign vals[SLOT_MA] = ma_val;
  assign vals[SLOT_WB] = wb_val;
  assign oks[SLOT_EX]  = ex_ok;
  assign oks[SLOT_MA]  = ma_ok;
  assign oks[SLOT_WB]  = wb_ok;

  logic [NSRC-1:0][IDXW-1:0] s_idx;
  logic [NSRC-1:0]           s_used;
  logic [NSRC-1:0][XLEN-1:0] s_rf;
  logic [NSRC-1:0][XLEN-1:0] s_opnd;
  logic [NSRC-1:0]           s_haz;

  assign s_idx  = {src2_idx, src1_idx};
  assign s_used = {src2_used, src1_used};
  assign s_rf   = {rf_rd2, rf_rd1};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    fwd_operand_sel #(.XLEN(XLEN), .IDXW(IDXW), .NREC(NREC)) u_sel (
      .idx     (s_idx[s]),
      .used    (s_used[s]),
      .rf_val  (s_rf[s]),
      .rec_tag (tags),
      .rec_val (vals),
      .rec_ok  (oks),
      .opnd    (s_opnd[s]),
      .hazard  (s_haz[s])
    );
  end

  assign opnd1     = s_opnd[0];
  assign opnd2     = s_opnd[1];
  assign dec_ready = ~(|s_haz);
endmodule

// File: rtl/operand_fwd_chk.sv
module operand_fwd_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 5
) (
  input logic [IDXW-1:0] src1_idx,
  input logic            src1_used,
  input logic [XLEN-1:0] rf_rd1,
  input logic [IDXW-1:0] src2_idx,
  input logic            src2_used,
  input logic [XLEN-1:0] rf_rd2,
  input logic [IDXW-1:0] ex_tag,
  input logic [XLEN-1:0] ex_val,
  input logic            ex_ok,
  input logic [IDXW-1:0] ma_tag,
  input logic [XLEN-1:0] ma_val,
  input logic            ma_ok,
  input logic [IDXW-1:0] wb_tag,
  input logic [XLEN-1:0] wb_val,
  input logic            wb_ok,
  input logic [XLEN-1:0] opnd1,
  input logic [XLEN-1:0] opnd2,
  input logic            dec_ready
);
  logic any1, any2, need1;
  assign any1  = (src1_idx != '0) && (ex_tag == src1_idx || ma_tag == src1_idx || wb_tag == src1_idx);
  assign any2  = (src2_idx != '0) && (ex_tag == src2_idx || ma_tag == src2_idx || wb_tag == src2_idx);
  assign need1 = src1_used && any1;

  always_comb begin
    // R3: zero index resolves to zero
    if (src1_idx == '0) a_r3_zero_src1: assert (opnd1 == '0);
    if (src2_idx == '0) a_r3_zero_src2: assert (opnd2 == '0);
    // R1: execute result wins whenever it matches
    if (src1_idx != '0 && ex_tag == src1_idx) a_r1_ex_first: assert (opnd1 == ex_val);
    // R2: no match passes the register file through
    if (src1_idx != '0 && !any1) a_r2_rf_pass1: assert (opnd1 == rf_rd1);
    if (src2_idx != '0 && !any2) a_r2_rf_pass2: assert (opnd2 == rf_rd2);
    // R5: a valid execute match on both used sources leaves no stall
    if ((!src1_used || (src1_idx != '0 && ex_tag == src1_idx && ex_ok)) &&
        (!src2_used || (src2_idx != '0 && ex_tag == src2_idx && ex_ok)))
      a_r5_valid_young_go: assert (dec_ready);
    // R6 / R7: a stall needs a used operand with some match
    if (!dec_ready) a_r7_stall_cause: assert (need1 || (src2_used && any2));
    // R4: an invalid execute match on a used operand stalls
    if (src1_used && src1_idx != '0 && ex_tag == src1_idx && !ex_ok)
      a_r4_ex_pending_stall: assert (!dec_ready);
  end
endmodule

bind operand_fwd operand_fwd_chk #(.XLEN(XLEN), .IDXW(IDXW)) chk_i (.*);

// File: tb/operand_fwd_tb_top.sv
module operand_fwd_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [4:0]  src1_idx, src2_idx, ex_tag, ma_tag, wb_tag;
  logic        src1_used, src2_used, ex_ok, ma_ok, wb_ok;
  logic [31:0] rf_rd1, rf_rd2, ex_val, ma_val, wb_val, opnd1, opnd2;
  logic        dec_ready;

  operand_fwd dut_i (.*);

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // selection codes: 0 rf, 1 ex, 2 ma, 3 wb, 4 zero
  typedef struct packed {
    logic [4:0] s1; logic u1; logic [4:0] s2; logic u2;
    logic [4:0] et; logic eo; logic [4:0] mt; logic mo; logic [4:0] wt; logic wo;
    logic [2:0] e1; logic [2:0] e2; logic rdy;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{5'd5, 1'b1, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 3'd0, 3'd0, 1'b1}, // R2
    '{5'd5, 1'b1, 5'd6, 1'b1, 5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 3'd1, 3'd0, 1'b1}, // R1
    '{5'd5, 1'b1, 5'd6, 1'b1, 5'd0, 1'b0, 5'd6, 1'b1, 5'd0, 1'b0, 3'd0, 3'd2, 1'b1}, // R1
    '{5'd5, 1'b1, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 1'b1, 3'd3, 3'd0, 1'b1}, // R1
    '{5'd5, 1'b1, 5'd5, 1'b1, 5'd5, 1'b1, 5'd5, 1'b1, 5'd5, 1'b1, 3'd1, 3'd1, 1'b1}, // R1
    '{5'd7, 1'b1, 5'd7, 1'b1, 5'd9, 1'b1, 5'd7, 1'b1, 5'd7, 1'b1, 3'd2, 3'd2, 1'b1}, // R1
    '{5'd3, 1'b1, 5'd4, 1'b1, 5'd3, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 3'd1, 3'd0, 1'b0}, // R4
    '{5'd3, 1'b1, 5'd4, 1'b0, 5'd4, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 3'd0, 3'd1, 1'b1}, // R6
    '{5'd3, 1'b1, 5'd4, 1'b1, 5'd3, 1'b0, 5'd3, 1'b1, 5'd3, 1'b1, 3'd1, 3'd0, 1'b0}, // R5
    '{5'd3, 1'b1, 5'd4, 1'b1, 5'd3, 1'b1, 5'd3, 1'b0, 5'd3, 1'b0, 3'd1, 3'd0, 1'b1}, // R5
    '{5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b1, 3'd4, 3'd4, 1'b1}, // R3
    '{5'd2, 1'b1, 5'd8, 1'b1, 5'd9, 1'b0, 5'd10, 1'b0, 5'd11, 1'b0, 3'd0, 3'd0, 1'b1}, // R8
    '{5'd2, 1'b1, 5'd8, 1'b1, 5'd0, 1'b0, 5'd8, 1'b0, 5'd0, 1'b0, 3'd0, 3'd2, 1'b0}, // R7
    '{5'd31, 1'b1, 5'd30, 1'b0, 5'd31, 1'b1, 5'd30, 1'b0, 5'd0, 1'b0, 3'd1, 3'd2, 1'b1}, // R6
    '{5'd0, 1'b1, 5'd6, 1'b1, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 3'd4, 3'd1, 1'b1}  // R3
  };

  function automatic logic [31:0] pick(input logic [2:0] code, input logic [31:0] rf);
    case (code)
      3'd1: pick = ex_val;
      3'd2: pick = ma_val;
      3'd3: pick = wb_val;
      3'd4: pick = 32'h0;
      default: pick = rf;
    endcase
  endfunction

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_vals(input int k);
    rf_rd1 = 32'h1000_0000 + k;
    rf_rd2 = 32'h2000_0000 + k;
    ex_val = 32'hE000_0000 + k;
    ma_val = 32'hA000_0000 + k;
    wb_val = 32'hB000_0000 + k;
  endtask

  initial begin
    src1_idx = '0; src2_idx = '0; src1_used = 0; src2_used = 0;
    ex_tag = '0; ma_tag = '0; wb_tag = '0; ex_ok = 0; ma_ok = 0; wb_ok = 0;
    set_vals(0); rf_rd1 = '0; rf_rd2 = '0;
    @(negedge clk); #1;
    // reset-like idle state: nothing in flight, operands zero, ready high
    chk32("R3 idle opnd1", opnd1, 32'h0);
    chk32("R3 idle opnd2", opnd2, 32'h0);
    chk32("R7 idle ready", {31'h0, dec_ready}, 32'h1);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      set_vals(k + 1);
      src1_idx = TBL[k].s1; src1_used = TBL[k].u1;
      src2_idx = TBL[k].s2; src2_used = TBL[k].u2;
      ex_tag = TBL[k].et; ex_ok = TBL[k].eo;
      ma_tag = TBL[k].mt; ma_ok = TBL[k].mo;
      wb_tag = TBL[k].wt; wb_ok = TBL[k].wo;
      #1;
      chk32($sformatf("R1/R2/R3 vec%0d opnd1", k), opnd1, pick(TBL[k].e1, rf_rd1));
      chk32($sformatf("R1/R2/R3 vec%0d opnd2", k), opnd2, pick(TBL[k].e2, rf_rd2));
      chk32($sformatf("R4/R5/R6/R7/R8 vec%0d ready", k), {31'h0, dec_ready}, {31'h0, TBL[k].rdy});
    end

    // R1: every nonzero index hit by all three slots returns the execute value
    for (int i = 1; i < 32; i++) begin
      @(negedge clk);
      set_vals(100 + i);
      src1_idx = i[4:0]; src1_used = 1; src2_idx = '0; src2_used = 0;
      ex_tag = i[4:0]; ex_ok = 1; ma_tag = i[4:0]; ma_ok = 1; wb_tag = i[4:0]; wb_ok = 1;
      #1;
      chk32("R1 sweep", opnd1, 32'hE000_0000 + 100 + i);
      chk32("R1 sweep ready", {31'h0, dec_ready}, 32'h1);
    end

    // R2: nonzero index with unrelated tags passes register file through
    for (int i = 1; i < 32; i++) begin
      @(negedge clk);
      set_vals(200 + i);
      src2_idx = i[4:0]; src2_used = 1; src1_idx = '0; src1_used = 1;
      ex_tag = 5'(i + 1); ma_tag = 5'(i + 2); wb_tag = 5'(i + 3);
      if (ex_tag == 0) ex_tag = 5'd1;
      ex_ok = 0; ma_ok = 0; wb_ok = 0;
      if (ex_tag == i[4:0] || ma_tag == i[4:0] || wb_tag == i[4:0]) continue;
      #1;
      chk32("R2 sweep", opnd2, 32'h2000_0000 + 200 + i);
      chk32("R8 sweep ready", {31'h0, dec_ready}, 32'h1);
      chk32("R3 sweep zero", opnd1, 32'h0);
    end

    // R4 on rs2 via writeback slot only, R6 then clears it by dropping use
    @(negedge clk);
    set_vals(300);
    src1_idx = 5'd1; src1_used = 1; src2_idx = 5'd12; src2_used = 1;
    ex_tag = '0; ex_ok = 0; ma_tag = '0; ma_ok = 0; wb_tag = 5'd12; wb_ok = 0;
    #1;
    chk32("R4 wb pending ready", {31'h0, dec_ready}, 32'h0);
    src2_used = 0; #1;
    chk32("R6 unused rs2 ready", {31'h0, dec_ready}, 32'h1);
    chk32("R2 rs1 unaffected", opnd1, 32'h1000_0000 + 300);
    done = 1'b1;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (done);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule